// File: doc/BRIEF.md
# Two-Output Grouped Interrupt Aggregator

This block gathers 224 interrupt request lines and steers each one to one of two parent interrupt outputs. Each source has four configuration bits held in banks of 32-bit words, one word per group of 32 sources. The bits are the trigger type, the active polarity, the output choice and the enable. Source n lives at bit (n mod 32) of word (n / 32) in every bank. Requests arrive asynchronously. They pass through a two-flop synchronizer before level or edge detection.

Edge-type sources latch a pending flag that software clears by writing ones to a clear bank. Level-type sources are pending exactly while their input sits at the active level. Software services each parent output by reading a group-summary word first. That word tells it which 32-source groups hold work for which output. It then reads the masked-pending word of that group for that output. Access goes through a plain word-addressed bus with a write strobe, a read strobe and registered read data.

Top module: `intc_dual_route`

## Requirements
- R1: After reset every configuration bit is zero, no source is pending, both parent outputs are low, and every readable word returns zero.
- R2: The configuration banks are read/write at word addresses 0 (type), 7 (polarity), 14 (output choice) and 21 (enable), each followed by six more words for groups 1 to 6. Read data appears on `bus_rdata` one clock after the cycle in which `bus_ren` is sampled high.
- R3: A source whose type bit is 1 latches pending on its active edge and holds it until cleared. Polarity bit 0 selects the rising edge and 1 selects the falling edge. Changing the input back does not drop the latch.
- R4: Writing a word at addresses 32 to 38 clears the edge latch of every source whose bit is 1 in that word. Bits written as 0 have no effect. If an edge and a clear arrive in the same cycle, the edge wins.
- R5: A source whose type bit is 0 is pending exactly while its input is at the active level (polarity 0 high, 1 low). A clear write does not remove it while the level persists. After the input changes, the parent output follows at the second rising clock edge.
- R6: An output-choice bit of 1 routes the source to parent output 0, and 0 routes it to parent output 1.
- R7: Masked-pending words at addresses 46 to 52 (output 0) and 39 to 45 (output 1) equal pending AND enable AND the route for that output. A latched edge survives while its enable is 0 and shows once the enable is set.
- R8: The summary word at address 63 sets bit g (g = 0 to 6) when group g has a masked-pending source for output 1. It sets bit 8+g for output 0. All other bits read as zero.
- R9: `irq_out0` is the OR of summary bits 14:8, and `irq_out1` is the OR of summary bits 6:0.
- R10: Writes to the masked-pending words, the summary word or unmapped addresses change no state. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 224 | Asynchronous interrupt request lines |
| bus_addr | input | 6 | Word address |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out0 | output | 1 | Parent interrupt output 0 |
| irq_out1 | output | 1 | Parent interrupt output 1 |

## Verification
The hardest state to reach from the ports is a latched edge that sits hidden behind a zero enable. It must stay invisible on the masked word, the summary and the output, and then appear once the enable opens. The stimulus holds a request line at its idle level through reset and configuration. It arms the source as a falling edge with the enable off, drops the line, and opens the enable only after checking that nothing leaks out. The same approach covers an active-low level source: the line is held high before its polarity is set, so the change of polarity never fakes a request.

// File: rtl/intc_pkg.sv
// Shared constants and the register-decode type for the grouped interrupt
// aggregator. Assumes 32-bit bus words and at most eight groups.
package intc_pkg;

    localparam int WORD_W    = 32;
    localparam int CFG_BANKS = 4;
    localparam int RO_BANKS  = 3;

    // Which register an address selects; config banks first, in map order.
    typedef enum logic [3:0] {
        BK_TYPE = 4'd0,
        BK_POL  = 4'd1,
        BK_SEL  = 4'd2,
        BK_EN   = 4'd3,
        BK_CLR  = 4'd4,
        BK_M1   = 4'd5,
        BK_M0   = 4'd6,
        BK_SUM  = 4'd7,
        BK_NONE = 4'd8
    } bank_sel_e;

endpackage

// File: rtl/intc_src_front.sv
// Request front end: a chain of synchronizer flops per source, then
// polarity-adjusted level and edge detection.
// Assumes pol_i is quasi-static; a polarity flip never creates an edge
// because the current and previous samples both flip together.
module intc_src_front #(
    parameter int NSRC        = 224,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] pol_i,
    output logic [NSRC-1:0] act_lvl_o,
    output logic [NSRC-1:0] act_edge_o
);

    localparam int CHAIN = SYNC_STAGES + 1;

    logic [NSRC-1:0] stage_q [CHAIN];
    logic [NSRC-1:0] now_act;
    logic [NSRC-1:0] prev_act;

    // Shift the raw requests through the synchronizer and history flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < CHAIN; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= src_in;
            for (int s = 1; s < CHAIN; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    // Fold in polarity so that 1 always means "active".
    always_comb begin
        now_act  = stage_q[SYNC_STAGES-1] ^ pol_i;
        prev_act = stage_q[SYNC_STAGES]   ^ pol_i;
    end

    assign act_lvl_o  = now_act;
    assign act_edge_o = now_act & ~prev_act;

endmodule

// File: rtl/intc_pend_route.sv
// Pending state and routing: edge latches with write-1-to-clear, level
// pass-through, per-output masking, per-group summary and parent outputs.
// Assumes NUM_GRP <= 8 so both summary fields fit in one word.
module intc_pend_route #(
    parameter int NUM_GRP = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GRP*intc_pkg::WORD_W-1:0] type_i,
    input  logic [NUM_GRP*intc_pkg::WORD_W-1:0] en_i,
    input  logic [NUM_GRP*intc_pkg::WORD_W-1:0] sel_i,
    input  logic [NUM_GRP*intc_pkg::WORD_W-1:0] act_lvl_i,
    input  logic [NUM_GRP*intc_pkg::WORD_W-1:0] act_edge_i,
    input  logic [NUM_GRP*intc_pkg::WORD_W-1:0] clr_i,
    output logic [NUM_GRP*intc_pkg::WORD_W-1:0] masked0_o,
    output logic [NUM_GRP*intc_pkg::WORD_W-1:0] masked1_o,
    output logic [intc_pkg::WORD_W-1:0]         summary_o,
    output logic                          irq0_o,
    output logic                          irq1_o
);
    import intc_pkg::*;

    localparam int NBITS   = NUM_GRP * WORD_W;
    localparam int OUT0_SH = 8;

    logic [NBITS-1:0] edge_q;
    logic [NBITS-1:0] edge_set;
    logic [NBITS-1:0] pend;

    assign edge_set = act_edge_i & type_i;

    // Edge latch: a new edge sets, a clear bit resets, and set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= (edge_q & ~clr_i) | edge_set;
    end

    // Effective pending: the latch for edge sources, the live level otherwise.
    always_comb begin
        pend      = (type_i & edge_q) | (~type_i & act_lvl_i);
        masked0_o = pend & en_i & sel_i;
        masked1_o = pend & en_i & ~sel_i;
    end

    // Per-group summary bits, one field for each parent output.
    always_comb begin
        summary_o = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            summary_o[g]           = |masked1_o[g*WORD_W +: WORD_W];
            summary_o[OUT0_SH + g] = |masked0_o[g*WORD_W +: WORD_W];
        end
    end

    // Parent outputs straight from the masked vectors.
    assign irq0_o = |masked0_o;
    assign irq1_o = |masked1_o;

    // R3
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_set) |=> (($past(edge_set) & ~edge_q) == '0));

    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~edge_set)) |=> (($past(clr_i & ~edge_set) & edge_q) == '0));

    // R9
    irq0_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq0_o == (|summary_o[OUT0_SH +: NUM_GRP]));

    // R9
    irq1_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq1_o == (|summary_o[NUM_GRP-1:0]));

endmodule

// File: rtl/intc_cfg_regs.sv
// Register block: address decode, the four read/write configuration banks,
// the clear strobe and the registered read-data mux.
// Assumes word addressing; region two starts at REGB_BASE with the summary
// word at REGB_BASE + SUM_OFS, beyond the three region-two banks.
module intc_cfg_regs #(
    parameter int NUM_GRP   = 7,
    parameter int ADDR_W    = 6,
    parameter int REGB_BASE = 32,
    parameter int SUM_OFS   = 31
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wen,
    input  logic                          bus_ren,
    input  logic [intc_pkg::WORD_W-1:0]   bus_wdata,
    output logic [intc_pkg::WORD_W-1:0]   bus_rdata,
    input  logic [NUM_GRP*intc_pkg::WORD_W-1:0] masked0_i,
    input  logic [NUM_GRP*intc_pkg::WORD_W-1:0] masked1_i,
    input  logic [intc_pkg::WORD_W-1:0]   summary_i,
    output logic [NUM_GRP*intc_pkg::WORD_W-1:0] type_o,
    output logic [NUM_GRP*intc_pkg::WORD_W-1:0] pol_o,
    output logic [NUM_GRP*intc_pkg::WORD_W-1:0] sel_o,
    output logic [NUM_GRP*intc_pkg::WORD_W-1:0] en_o,
    output logic [NUM_GRP*intc_pkg::WORD_W-1:0] clr_o
);
    import intc_pkg::*;

    localparam int NBITS   = NUM_GRP * WORD_W;
    localparam int CFG_TOP = CFG_BANKS * NUM_GRP;
    localparam int RO_TOP  = RO_BANKS * NUM_GRP;

    logic [NBITS-1:0]  bank_q [CFG_BANKS];
    logic [4*NBITS-1:0] cfg_flat;
    bank_sel_e         dec_bank;
    int                dec_grp;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] rdata_q;

    // Map a word address to a bank and a group index.
    always_comb begin
        int a;
        int b;
        a        = int'(bus_addr);
        b        = a - REGB_BASE;
        dec_bank = BK_NONE;
        dec_grp  = 0;
        if (a < REGB_BASE) begin
            if (a < CFG_TOP) begin
                dec_bank = bank_sel_e'(4'(a / NUM_GRP));
                dec_grp  = a % NUM_GRP;
            end
        end else if (b == SUM_OFS) begin
            dec_bank = BK_SUM;
        end else if (b < RO_TOP) begin
            dec_bank = bank_sel_e'(4'(CFG_BANKS + b / NUM_GRP));
            dec_grp  = b % NUM_GRP;
        end
    end

    // Store writes to the configuration banks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < CFG_BANKS; k++) bank_q[k] <= '0;
        end else if (bus_wen && (int'(dec_bank) < CFG_BANKS)) begin
            bank_q[int'(dec_bank)][dec_grp*WORD_W +: WORD_W] <= bus_wdata;
        end
    end

    // One-cycle clear strobe aimed at the addressed group.
    always_comb begin
        clr_o = '0;
        if (bus_wen && dec_bank == BK_CLR)
            clr_o[dec_grp*WORD_W +: WORD_W] = bus_wdata;
    end

    // Select the word being read.
    always_comb begin
        case (dec_bank)
            BK_TYPE, BK_POL, BK_SEL, BK_EN:
                rd_word = bank_q[int'(dec_bank)][dec_grp*WORD_W +: WORD_W];
            BK_M1:   rd_word = masked1_i[dec_grp*WORD_W +: WORD_W];
            BK_M0:   rd_word = masked0_i[dec_grp*WORD_W +: WORD_W];
            BK_SUM:  rd_word = summary_i;
            default: rd_word = '0;
        endcase
    end

    // Register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (bus_ren) rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;
    assign type_o    = bank_q[BK_TYPE];
    assign pol_o     = bank_q[BK_POL];
    assign sel_o     = bank_q[BK_SEL];
    assign en_o      = bank_q[BK_EN];
    assign cfg_flat  = {bank_q[3], bank_q[2], bank_q[1], bank_q[0]};

    // R10
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && (int'(dec_bank) >= CFG_BANKS)) |=> $stable(cfg_flat));

endmodule

// File: rtl/intc_dual_route.sv
// Top of the two-output grouped interrupt aggregator: joins the register
// block, the request front end and the pending/routing stage.
// Assumes NUM_GRP <= 8 and that region two sits above the config banks.
module intc_dual_route #(
    parameter int NUM_GRP     = 7,
    parameter int ADDR_W      = 6,
    parameter int REGB_BASE   = 32,
    parameter int SUM_OFS     = 31,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_GRP*intc_pkg::WORD_W-1:0]   src_in,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic                                  bus_wen,
    input  logic                                  bus_ren,
    input  logic [intc_pkg::WORD_W-1:0]           bus_wdata,
    output logic [intc_pkg::WORD_W-1:0]           bus_rdata,
    output logic                                  irq_out0,
    output logic                                  irq_out1
);
    import intc_pkg::*;

    localparam int NBITS = NUM_GRP * WORD_W;

    logic [NBITS-1:0]  type_w, pol_w, sel_w, en_w, clr_w;
    logic [NBITS-1:0]  lvl_w, edge_w;
    logic [NBITS-1:0]  m0_w, m1_w;
    logic [WORD_W-1:0] sum_w;

    intc_cfg_regs #(
        .NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W),
        .REGB_BASE(REGB_BASE), .SUM_OFS(SUM_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_ren(bus_ren),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .masked0_i(m0_w), .masked1_i(m1_w), .summary_i(sum_w),
        .type_o(type_w), .pol_o(pol_w), .sel_o(sel_w), .en_o(en_w),
        .clr_o(clr_w)
    );

    intc_src_front #(
        .NSRC(NBITS), .SYNC_STAGES(SYNC_STAGES)
    ) u_front (
        .clk(clk), .rst_n(rst_n),
        .src_in(src_in), .pol_i(pol_w),
        .act_lvl_o(lvl_w), .act_edge_o(edge_w)
    );

    intc_pend_route #(
        .NUM_GRP(NUM_GRP)
    ) u_pend (
        .clk(clk), .rst_n(rst_n),
        .type_i(type_w), .en_i(en_w), .sel_i(sel_w),
        .act_lvl_i(lvl_w), .act_edge_i(edge_w), .clr_i(clr_w),
        .masked0_o(m0_w), .masked1_o(m1_w), .summary_o(sum_w),
        .irq0_o(irq_out0), .irq1_o(irq_out1)
    );

endmodule

// File: tb/intc_dual_route_test.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them
// one clock after the read strobe; output pins are checked directly.
module intc_dual_route_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [223:0] src = '0;
    logic [5:0]   bus_addr = '0;
    logic         bus_wen = 1'b0;
    logic         bus_ren = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_out0, irq_out1;

    int n_chk = 0;
    int n_fail = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    intc_dual_route uut (
        .clk(clk), .rst_n(rst_n), .src_in(src),
        .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_ren(bus_ren),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out0(irq_out0), .irq_out1(irq_out1)
    );

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = 6'(a); bus_ren = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_ren = 1'b0;
    endtask

    task automatic irq_chk(input logic e0, input logic e1, input string tag);
        chk32({tag, " irq_out0"}, {31'd0, irq_out0}, {31'd0, e0});
        chk32({tag, " irq_out1"}, {31'd0, irq_out1}, {31'd0, e1});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Record in which cycle a read strobe was taken.
    always @(posedge clk) rd_seen <= bus_ren;

    // Monitor: compare read data against the scoreboard queue.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: actual %h expected none", bus_rdata);
            end else begin
                chk32(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic summary_line;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_line();
        $finish;
    end

    initial begin
        src[40]  = 1'b1;
        src[223] = 1'b1;
        idle(4);
        rst_n = 1'b1;
        idle(3);

        // R1 reset state
        irq_chk(1'b0, 1'b0, "R1 reset");
        rd(0,  32'h0, "R1 type word0");
        rd(27, 32'h0, "R1 enable word6");
        rd(46, 32'h0, "R1 masked0 word0");
        rd(63, 32'h0, "R1 summary");

        // R2 readback of configuration banks
        wr(3, 32'hA5A5_0F0F);
        rd(3, 32'hA5A5_0F0F, "R2 type word3");
        wr(17, 32'h1234_5678);
        rd(17, 32'h1234_5678, "R2 select word3");
        wr(3, 32'h0);
        wr(17, 32'h0);
        rd(17, 32'h0, "R2 select restored");

        // R3/R6 rising edge on source 5 routed to output 0
        wr(0, 32'h20);
        wr(14, 32'h20);
        wr(21, 32'h20);
        @(negedge clk); src[5] = 1'b1;
        idle(3);
        src[5] = 1'b0;
        idle(3);
        irq_chk(1'b1, 1'b0, "R3 R6 edge src5 held");
        rd(46, 32'h20, "R7 masked0 word0");
        rd(39, 32'h0,  "R6 masked1 word0");
        rd(63, 32'h100, "R8 summary out0 group0");
        // R4 zeros in the clear word have no effect
        wr(32, 32'h40);
        idle(1);
        irq_chk(1'b1, 1'b0, "R4 clear other bit");
        wr(32, 32'h20);
        idle(1);
        irq_chk(1'b0, 1'b0, "R4 cleared src5");
        rd(63, 32'h0, "R4 summary after clear");

        // R5 active-low level on source 40 (group1 bit8) to output 1
        wr(8, 32'h100);
        wr(22, 32'h100);
        idle(2);
        irq_chk(1'b0, 1'b0, "R5 level idle high");
        src[40] = 1'b0;
        @(negedge clk);
        irq_chk(1'b0, 1'b0, "R5 one edge after change");
        @(negedge clk);
        irq_chk(1'b0, 1'b1, "R5 two edges after change");
        rd(40, 32'h100, "R6 masked1 word1");
        rd(63, 32'h2, "R8 summary out1 group1");
        wr(33, 32'h100);
        idle(2);
        irq_chk(1'b0, 1'b1, "R5 clear ignored while active");
        src[40] = 1'b1;
        idle(3);
        irq_chk(1'b0, 1'b0, "R5 level released");

        // R7 falling edge on source 223 latched while disabled
        wr(13, 32'h8000_0000);
        wr(6,  32'h8000_0000);
        wr(20, 32'h8000_0000);
        idle(2);
        @(negedge clk); src[223] = 1'b0;
        idle(4);
        irq_chk(1'b0, 1'b0, "R7 disabled edge hidden");
        rd(52, 32'h0, "R7 masked0 word6 disabled");
        rd(63, 32'h0, "R7 summary disabled");
        wr(27, 32'h8000_0000);
        idle(1);
        irq_chk(1'b1, 1'b0, "R7 enable reveals latch");
        rd(52, 32'h8000_0000, "R7 masked0 word6");
        rd(63, 32'h4000, "R8 summary out0 group6");

        // R10 writes to read-only or unmapped words change nothing
        wr(63, 32'hFFFF_FFFF);
        wr(52, 32'h0);
        wr(28, 32'hFFFF_FFFF);
        rd(28, 32'h0, "R10 unmapped region one");
        rd(60, 32'h0, "R10 unmapped region two");
        rd(63, 32'h4000, "R10 summary unchanged");
        rd(6, 32'h8000_0000, "R10 type word6 unchanged");
        rd(0, 32'h20, "R10 type word0 unchanged");
        irq_chk(1'b1, 1'b0, "R9 output follows summary");

        wr(38, 32'h8000_0000);
        idle(1);
        irq_chk(1'b0, 1'b0, "R9 output low after clear");
        rd(63, 32'h0, "R8 summary empty");

        idle(4);
        summary_line();
        $finish;
    end

endmodule